// File: doc/BRIEF.md
# Reset Sequencer with Strap Latch

This block produces the reset outputs of a chip from two active-low board-level reset pins and three reset request lines from inside the chip. A cold power-on reset clears everything, including the test and debug logic. A warm reset clears the functional logic but leaves the test/debug domain running. A warm reset is accepted only after its pin has stayed low for a minimum number of reference-clock cycles. Shorter pulses on that pin are treated as noise.

When a power-on or warm reset ends, the block captures a vector of configuration strap pins into a register. Only after that does it release the functional domain, so downstream logic never sees a strap value that is still changing. Internal max and system resets hold the functional domain and pull the active-low status output low. A CPU-only reset holds the functional domain but keeps the status output high. None of the three internal resets re-captures the straps. Both pins go through two-flop synchronisers. The power-on pin also clears the block asynchronously.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_n` is low, `func_rst_n`, `test_rst_n` and `rst_stat_n` are all low.
- R2: A qualified warm reset drives `func_rst_n` and `rst_stat_n` low and keeps `test_rst_n` high.
- R3: A low pulse on `warm_n` lasting fewer than WARM_MIN (default 24) clock cycles has no effect on any output. A pulse of WARM_MIN cycles or more is accepted as a warm reset.
- R4: When a power-on or warm reset ends, `strap_out` takes the value of `strap_in` sampled on the first clock edge after the synchronised reset is seen released.
- R5: While `max_req` or `sys_req` is high (active-high, synchronous to `clk`), `func_rst_n` and `rst_stat_n` are low one edge later, and `test_rst_n` stays high.
- R6: While `cpu_req` alone is high, `func_rst_n` is low and `rst_stat_n` stays high.
- R7: Outside a power-on or warm reset release, `strap_out` holds its value. Changes on `strap_in` are ignored, and the end of a max, system or CPU reset does not re-capture the straps.
- R8: `func_rst_n` rises exactly one clock cycle after the edge on which `strap_out` is updated.
- R9: If `por_n` goes low while a warm reset is active, the power-on reset takes priority and `test_rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Cold power-on reset pin, active low, asynchronous |
| warm_n | input | 1 | Warm reset pin, active low, asynchronous, width-filtered |
| max_req | input | 1 | Internal max reset request, active high, synchronous |
| sys_req | input | 1 | Internal system reset request, active high, synchronous |
| cpu_req | input | 1 | Internal CPU-only reset request, active high, synchronous |
| strap_in | input | STRAP_W | Configuration strap pins |
| func_rst_n | output | 1 | Functional domain reset, active low |
| test_rst_n | output | 1 | Test/debug domain reset, active low |
| rst_stat_n | output | 1 | Reset status, active low |
| strap_out | output | STRAP_W | Latched strap value |

## Verification
A sequencer stuck in the wrong state shows up at the ports within a few cycles. A missing capture step releases `func_rst_n` on the same edge the straps change. A skipped hold keeps `func_rst_n` high during an accepted warm reset. A pulse-width counter that is off by one lets a 23-cycle pulse pull `func_rst_n` low, or lets a 24-cycle pulse leave the straps unchanged, and either shows within about thirty cycles of the pulse. A wrong status decode or a wrong domain split shows at once as `rst_stat_n` or `test_rst_n` at the wrong level while the corresponding request is held.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_CAPT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       func_n;
        logic       test_n;
        logic       stat_n;
    } seq_regs_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rst_pulse_qual.sv
module rst_pulse_qual #(
    parameter int MIN_LOW = 24,
    localparam int CNT_W  = $clog2(MIN_LOW + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic enable,
    input  logic low_in,
    output logic active
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
    } qual_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);

    qual_t qual_d;
    qual_t qual_q;

    always_comb begin
        qual_d = qual_q;
        if (!enable) begin
            qual_d = '0;
        end else if (low_in) begin
            if (qual_q.cnt == LAST) qual_d.act = 1'b1;
            else                    qual_d.cnt = qual_q.cnt + 1'b1;
        end else begin
            qual_d = '0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) qual_q <= '0;
        else         qual_q <= qual_d;
    end

    assign active = qual_q.act;
endmodule

// File: rtl/rst_strap_latch.sv
module rst_strap_latch #(
    parameter int STRAP_W = 20
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic               cap_en,
    input  logic [STRAP_W-1:0] pins,
    output logic [STRAP_W-1:0] held
);
    logic [STRAP_W-1:0] held_d;
    logic [STRAP_W-1:0] held_q;

    always_comb held_d = cap_en ? pins : held_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) held_q <= '0;
        else         held_q <= held_d;
    end

    assign held = held_q;
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int STRAP_W     = 20,
    parameter int WARM_MIN    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               warm_n,
    input  logic               max_req,
    input  logic               sys_req,
    input  logic               cpu_req,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               func_rst_n,
    output logic               test_rst_n,
    output logic               rst_stat_n,
    output logic [STRAP_W-1:0] strap_out
);
    logic por_s;
    logic warm_s;
    logic warm_act;
    logic hold_src;
    logic cap_en;

    seq_regs_t seq_d;
    seq_regs_t seq_q;

    rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
        .clk(clk), .arst_n(por_n), .din(1'b1), .dout(por_s)
    );

    rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_warm_sync (
        .clk(clk), .arst_n(por_n), .din(warm_n), .dout(warm_s)
    );

    rst_pulse_qual #(.MIN_LOW(WARM_MIN)) u_warm_qual (
        .clk(clk), .arst_n(por_n), .enable(por_s), .low_in(!warm_s),
        .active(warm_act)
    );

    assign hold_src = !por_s || warm_act;
    assign cap_en   = (seq_q.state == SEQ_HOLD) && !hold_src;

    always_comb begin
        seq_d = seq_q;
        if (hold_src) begin
            seq_d.state = SEQ_HOLD;
        end else begin
            case (seq_q.state)
                SEQ_HOLD: seq_d.state = SEQ_CAPT;
                SEQ_CAPT: seq_d.state = SEQ_RUN;
                default:  seq_d.state = SEQ_RUN;
            endcase
        end
        seq_d.func_n = (seq_d.state == SEQ_RUN) && !max_req && !sys_req && !cpu_req;
        seq_d.stat_n = (seq_d.state == SEQ_RUN) && !max_req && !sys_req;
        seq_d.test_n = por_s;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) seq_q <= '{state: SEQ_HOLD, func_n: 1'b0, test_n: 1'b0, stat_n: 1'b0};
        else        seq_q <= seq_d;
    end

    rst_strap_latch #(.STRAP_W(STRAP_W)) u_straps (
        .clk(clk), .arst_n(por_n), .cap_en(cap_en), .pins(strap_in),
        .held(strap_out)
    );

    assign func_rst_n = seq_q.func_n;
    assign test_rst_n = seq_q.test_n;
    assign rst_stat_n = seq_q.stat_n;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int STRAP_W = 20
) (
    input logic               clk,
    input logic               por_n,
    input logic               cpu_req,
    input logic               max_req,
    input logic               sys_req,
    input logic               hold_src,
    input logic               func_rst_n,
    input logic               test_rst_n,
    input logic               rst_stat_n,
    input logic [STRAP_W-1:0] strap_out
);
    AST_TEST_IMPLIES_FUNC: assert property (@(posedge clk) disable iff (!por_n)
        !test_rst_n |-> !func_rst_n); // R2

    AST_STATUS_IMPLIES_FUNC: assert property (@(posedge clk) disable iff (!por_n)
        !rst_stat_n |-> !func_rst_n); // R5

    AST_STRAP_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (func_rst_n && $past(func_rst_n)) |-> $stable(strap_out)); // R7

    AST_CAPTURE_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(strap_out) |-> !func_rst_n); // R8

    AST_CPU_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_req && !max_req && !sys_req && !hold_src && rst_stat_n) |=> rst_stat_n); // R6
endmodule

bind rst_seq_top rst_seq_chk #(.STRAP_W(STRAP_W)) u_chk (
    .clk(clk), .por_n(por_n), .cpu_req(cpu_req), .max_req(max_req),
    .sys_req(sys_req), .hold_src(hold_src), .func_rst_n(func_rst_n),
    .test_rst_n(test_rst_n), .rst_stat_n(rst_stat_n), .strap_out(strap_out)
);

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
    localparam int SW = 20;
    localparam int WMIN = 24;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          warm_n = 1'b1;
    logic          max_req = 1'b0;
    logic          sys_req = 1'b0;
    logic          cpu_req = 1'b0;
    logic [SW-1:0] strap_in = '0;
    logic          func_rst_n;
    logic          test_rst_n;
    logic          rst_stat_n;
    logic [SW-1:0] strap_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rst_seq_top #(.STRAP_W(SW), .WARM_MIN(WMIN)) dut_i (
        .clk(clk), .por_n(por_n), .warm_n(warm_n), .max_req(max_req),
        .sys_req(sys_req), .cpu_req(cpu_req), .strap_in(strap_in),
        .func_rst_n(func_rst_n), .test_rst_n(test_rst_n),
        .rst_stat_n(rst_stat_n), .strap_out(strap_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Reset input was just released: check strap capture and the one-cycle lag.
    task automatic meas_release(input logic [SW-1:0] exp, input string req);
        int cap = -1;
        int rel = -1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cap < 0 && strap_out == exp) cap = i;
            if (rel < 0 && func_rst_n) rel = i;
        end
        chk(req, "strap captured", 64'(strap_out), 64'(exp));
        chk("R8", "release lag after capture", 64'(rel - cap), 64'd1);
        chk(req, "status released", 64'(rst_stat_n), 64'd1);
        chk(req, "test domain out of reset", 64'(test_rst_n), 64'd1);
    endtask

    task automatic t_cold;
        strap_in = 20'h1A5C3;
        wait_cyc(3);
        chk("R1", "func during por", 64'(func_rst_n), 64'd0);
        chk("R1", "test during por", 64'(test_rst_n), 64'd0);
        chk("R1", "status during por", 64'(rst_stat_n), 64'd0);
        por_n = 1'b1;
        meas_release(20'h1A5C3, "R4");
    endtask

    task automatic t_warm_ok;
        strap_in = 20'h0BEEF;
        warm_n = 1'b0;
        wait_cyc(WMIN + 6);
        chk("R2", "func in warm", 64'(func_rst_n), 64'd0);
        chk("R2", "status in warm", 64'(rst_stat_n), 64'd0);
        chk("R2", "test kept in warm", 64'(test_rst_n), 64'd1);
        warm_n = 1'b1;
        meas_release(20'h0BEEF, "R4");
    endtask

    task automatic t_warm_short;
        int drops = 0;
        strap_in = 20'h5A5A5;
        warm_n = 1'b0;
        for (int i = 0; i < WMIN - 1; i++) begin
            @(negedge clk);
            if (!func_rst_n || !rst_stat_n) drops++;
        end
        warm_n = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!func_rst_n || !rst_stat_n) drops++;
        end
        chk("R3", "short pulse output drops", 64'(drops), 64'd0);
        chk("R3", "short pulse straps", 64'(strap_out), 64'(20'h0BEEF));
    endtask

    task automatic t_warm_edge;
        int seen_low = 0;
        strap_in = 20'h7C001;
        warm_n = 1'b0;
        wait_cyc(WMIN);
        warm_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!func_rst_n) seen_low = 1;
        end
        chk("R3", "minimum pulse accepted", 64'(seen_low), 64'd1);
        chk("R3", "minimum pulse straps", 64'(strap_out), 64'(20'h7C001));
    endtask

    task automatic t_max_sys;
        strap_in = 20'h33333;
        max_req = 1'b1;
        wait_cyc(2);
        chk("R5", "func in max", 64'(func_rst_n), 64'd0);
        chk("R5", "status in max", 64'(rst_stat_n), 64'd0);
        chk("R5", "test in max", 64'(test_rst_n), 64'd1);
        max_req = 1'b0;
        wait_cyc(3);
        chk("R7", "func after max", 64'(func_rst_n), 64'd1);
        chk("R7", "no recapture after max", 64'(strap_out), 64'(20'h7C001));
        sys_req = 1'b1;
        wait_cyc(2);
        chk("R5", "func in sys", 64'(func_rst_n), 64'd0);
        chk("R5", "status in sys", 64'(rst_stat_n), 64'd0);
        sys_req = 1'b0;
        wait_cyc(3);
        chk("R7", "no recapture after sys", 64'(strap_out), 64'(20'h7C001));
    endtask

    task automatic t_cpu;
        int stat_drops = 0;
        strap_in = 20'h44444;
        cpu_req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!rst_stat_n) stat_drops++;
        end
        chk("R6", "func in cpu reset", 64'(func_rst_n), 64'd0);
        chk("R6", "status drops in cpu reset", 64'(stat_drops), 64'd0);
        cpu_req = 1'b0;
        wait_cyc(3);
        chk("R6", "func after cpu", 64'(func_rst_n), 64'd1);
        chk("R7", "no recapture after cpu", 64'(strap_out), 64'(20'h7C001));
    endtask

    task automatic t_por_over_warm;
        warm_n = 1'b0;
        wait_cyc(WMIN + 6);
        chk("R9", "test before por", 64'(test_rst_n), 64'd1);
        por_n = 1'b0;
        wait_cyc(1);
        chk("R9", "test when por joins warm", 64'(test_rst_n), 64'd0);
        chk("R9", "func when por joins warm", 64'(func_rst_n), 64'd0);
        wait_cyc(3);
        warm_n = 1'b1;
        strap_in = 20'h2F0F0;
        wait_cyc(2);
        por_n = 1'b1;
        meas_release(20'h2F0F0, "R9");
    endtask

    initial begin
        t_cold();
        t_warm_ok();
        t_warm_short();
        t_warm_edge();
        t_max_sys();
        t_cpu();
        t_por_over_warm();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule